// File: doc/BRIEF.md
# Port-Window Address Translator with Byte-Lane Merge

This block turns legacy I/O port accesses from a CPU into transactions on a memory-mapped peripheral bus. Each request carries a 16-bit port number, an access size (byte, word or long), a direction and write data. The port is matched against a fixed set of windows. Each window maps the port either linearly onto a device base or, for the peripheral that spaces its registers two bytes apart, onto a base plus the port shifted left by one. A port that matches no window is sent to a harmless fallback address, and a sticky flag records that this happened.

One window holds a 16-bit device whose two byte enables are tied together, so a plain byte write there would overwrite the other byte. For a byte write into that window the block reads the aligned 16-bit word, puts the new byte into the correct lane, and writes the whole word back. Reads and wider accesses in that window go out as a single transaction.

Both the request side and the response side use valid/ready. A request is taken only when `req_ready` is high, and only one request is in flight at a time. The bus side holds `bus_valid` and every bus field steady until `bus_ready`. `bus_ready` also marks the cycle in which `bus_rdata` is valid. A response holds `rsp_valid` and `rsp_rdata` until the CPU side raises `rsp_ready`, so the CPU can stall the block for as long as it needs.

Top module: `port_window_xlate`

## Requirements
- R1: Ports 0x300..0x30F map to 0xA7500000 + (port - 0x300).
- R2: Ports 0x290..0x293 map to 0xA7700000 + (port - 0x290).
- R3: Ports 0x3F0..0x3F1, 0x1F0..0x1F7, 0x3F6, 0x170..0x177, 0x376, 0x3F8..0x407 and 0x2F8..0x307 map to 0xA7800000 + (port << 1).
- R4: Where windows overlap (ports 0x300..0x307), the R1 window wins over the shifted mapping.
- R5: A port in no window goes out as one transaction to 0xFF000030, for any size and direction.
- R6: `unexp_flag` goes high in the cycle after an R5 request is accepted and stays high. A `unexp_clr` pulse clears it one cycle later. If a fallback request is accepted in the same cycle as `unexp_clr`, the flag stays set.
- R7: A byte write (size 0) into the R1 window becomes two bus transactions to the even-aligned address: first a read with `bus_be`=4'b0011, then a write with `bus_be`=4'b0011.
- R8: Lane rule for the merge: the new byte is `req_wdata[7:0]`. An odd port replaces bits 15:8 and keeps bits 7:0 of the read word. An even port replaces bits 7:0 and keeps bits 15:8. The write carries `{16'h0, merged}`.
- R9: Byte reads in the R1 window, at even or odd ports, are a single read at the exact mapped address. `rsp_rdata` returns `bus_rdata` as captured at the acknowledge.
- R10: Every other access is one transaction with `bus_wdata`=`req_wdata` unchanged and right-justified. `bus_be` is 4'b0001 for size 0, 4'b0011 for size 1, and 4'b1111 for size 2 or 3.
- R11: `req_ready` is low while a request is in flight. `bus_valid` and the bus fields hold until `bus_ready`. `rsp_valid` and `rsp_rdata` hold until `rsp_ready`. A merged write responds only after the second bus acknowledge.
- R12: After reset, `req_ready`=1, `bus_valid`=0, `rsp_valid`=0 and `unexp_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and taking a request |
| req_port | input | 16 | I/O port number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 long |
| req_wdata | input | 32 | Right-justified write data |
| rsp_valid | output | 1 | Completion available |
| rsp_ready | input | 1 | CPU side takes the completion |
| rsp_rdata | output | 32 | Read data; zero for writes |
| bus_valid | output | 1 | Bus transaction pending |
| bus_ready | input | 1 | Bus acknowledge; read data valid this cycle |
| bus_addr | output | 32 | Physical address |
| bus_write | output | 1 | Bus direction |
| bus_be | output | 4 | Byte enables |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data |
| unexp_clr | input | 1 | Clears the unexpected-port flag |
| unexp_flag | output | 1 | Sticky unexpected-port indication |

## Verification
A wrong decode shows up on `bus_addr` in the first cycle after the request is accepted, so address faults appear within one cycle of the acceptance. A wrong merge state shows up as a missing second transaction, a write issued before the read, or a wrong lane in `bus_wdata` during the second transaction, all within the two bus transactions. A handshake fault shows up as `req_ready` rising while a transaction is pending, or `rsp_valid` dropping while the CPU side is stalling. The bench stretches every bus transaction to two cycles and holds back `rsp_ready` so that both of these cases are exercised.

// File: rtl/pwx_pkg.sv
package pwx_pkg;

  localparam int PORT_W = 16;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int HALF_W = 16;

  localparam int NWIN      = 9;
  localparam int MERGE_WIN = 0;   // lowest index wins: merge window has top priority

  localparam logic [ADDR_W-1:0] FALLBACK_ADDR = 32'hFF00_0030;

  typedef struct packed {
    logic [PORT_W-1:0] lo;
    logic [PORT_W-1:0] hi;
    logic              shifted;
    logic [ADDR_W-1:0] base;
  } win_t;

  localparam win_t WIN_TABLE [NWIN] = '{
    '{16'h0300, 16'h030F, 1'b0, 32'hA750_0000},
    '{16'h0290, 16'h0293, 1'b0, 32'hA770_0000},
    '{16'h03F0, 16'h03F1, 1'b1, 32'hA780_0000},
    '{16'h01F0, 16'h01F7, 1'b1, 32'hA780_0000},
    '{16'h03F6, 16'h03F6, 1'b1, 32'hA780_0000},
    '{16'h0170, 16'h0177, 1'b1, 32'hA780_0000},
    '{16'h0376, 16'h0376, 1'b1, 32'hA780_0000},
    '{16'h03F8, 16'h0407, 1'b1, 32'hA780_0000},
    '{16'h02F8, 16'h0307, 1'b1, 32'hA780_0000}
  };

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_MRD,
    ST_MWR,
    ST_RESP
  } state_e;

  function automatic logic [BE_W-1:0] size_be(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_be = BE_W'(4'b0001);
      SZ_WORD: size_be = BE_W'(4'b0011);
      default: size_be = '1;
    endcase
  endfunction

endpackage

// File: rtl/pwx_decode.sv
module pwx_decode
  import pwx_pkg::*;
#(
  parameter int N_WIN     = NWIN,
  parameter int MERGE_IDX = MERGE_WIN
) (
  input  logic [PORT_W-1:0] port,
  output logic [ADDR_W-1:0] addr,
  output logic              merge_hit,
  output logic              miss
);

  logic [N_WIN-1:0]             hit;
  logic [N_WIN-1:0][ADDR_W-1:0] cand;

  for (genvar i = 0; i < N_WIN; i++) begin : g_win
    assign hit[i] = (port >= WIN_TABLE[i].lo) && (port <= WIN_TABLE[i].hi);
    if (WIN_TABLE[i].shifted) begin : g_shift
      assign cand[i] = WIN_TABLE[i].base + ADDR_W'({port, 1'b0});
    end else begin : g_linear
      assign cand[i] = WIN_TABLE[i].base + ADDR_W'(port - WIN_TABLE[i].lo);
    end
  end

  // Priority: the lowest-numbered matching window decides.
  always_comb begin
    addr      = FALLBACK_ADDR;
    merge_hit = 1'b0;
    for (int i = N_WIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        addr      = cand[i];
        merge_hit = (i == MERGE_IDX);
      end
    end
  end

  assign miss = ~|hit;

endmodule

// File: rtl/pwx_flag.sv
module pwx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (!rst_n)      flag <= 1'b0;
    else if (set)    flag <= 1'b1;
    else if (clr)    flag <= 1'b0;
  end

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  p_flag_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);
  p_flag_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

endmodule

// File: rtl/pwx_seq.sv
module pwx_seq
  import pwx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_odd,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic              dec_merge,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic [BE_W-1:0]   bus_be,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);

  localparam logic [BE_W-1:0] HALF_BE = BE_W'(4'b0011);

  state_e            state;
  logic [ADDR_W-1:0] r_addr;
  logic              r_write;
  logic [1:0]        r_size;
  logic [DATA_W-1:0] r_wdata;
  logic              r_odd;
  logic [HALF_W-1:0] r_merge;
  logic              accept;
  logic              merge_op;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign merge_op  = dec_merge && req_write && (req_size == SZ_BYTE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      r_addr    <= '0;
      r_write   <= 1'b0;
      r_size    <= '0;
      r_wdata   <= '0;
      r_odd     <= 1'b0;
      r_merge   <= '0;
      rsp_rdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          r_addr  <= merge_op ? {dec_addr[ADDR_W-1:1], 1'b0} : dec_addr;
          r_write <= req_write;
          r_size  <= req_size;
          r_wdata <= req_wdata;
          r_odd   <= req_odd;
          state   <= merge_op ? ST_MRD : ST_ISSUE;
        end
        ST_ISSUE: if (bus_ready) begin
          rsp_rdata <= r_write ? '0 : bus_rdata;
          state     <= ST_RESP;
        end
        ST_MRD: if (bus_ready) begin
          r_merge <= r_odd ? {r_wdata[7:0], bus_rdata[7:0]}
                           : {bus_rdata[15:8], r_wdata[7:0]};
          state   <= ST_MWR;
        end
        ST_MWR: if (bus_ready) begin
          rsp_rdata <= '0;
          state     <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_valid = (state == ST_ISSUE) || (state == ST_MRD) || (state == ST_MWR);
    bus_addr  = r_addr;
    bus_write = (state == ST_ISSUE) ? r_write : (state == ST_MWR);
    bus_be    = (state == ST_ISSUE) ? size_be(r_size) : HALF_BE;
    bus_wdata = (state == ST_MWR) ? DATA_W'(r_merge) : r_wdata;
  end

  assign rsp_valid = (state == ST_RESP);

  p_bus_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> bus_valid && $stable(bus_addr)
                                  && $stable(bus_write) && $stable(bus_be));
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_valid && !rsp_valid);
  p_merge_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MRD && bus_ready) |=> bus_valid && bus_write && $stable(bus_addr));
  p_merge_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MRD) |-> !bus_write && !bus_addr[0]);

endmodule

// File: rtl/port_window_xlate.sv
module port_window_xlate
  import pwx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PORT_W-1:0] req_port,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic [BE_W-1:0]   bus_be,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              unexp_clr,
  output logic              unexp_flag
);

  logic [ADDR_W-1:0] dec_addr;
  logic              dec_merge;
  logic              dec_miss;

  pwx_decode #(.N_WIN(NWIN), .MERGE_IDX(MERGE_WIN)) u_decode (
    .port      (req_port),
    .addr      (dec_addr),
    .merge_hit (dec_merge),
    .miss      (dec_miss)
  );

  pwx_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_odd   (req_port[0]),
    .req_write (req_write),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .dec_addr  (dec_addr),
    .dec_merge (dec_merge),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_addr  (bus_addr),
    .bus_write (bus_write),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  pwx_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (req_valid && req_ready && dec_miss),
    .clr   (unexp_clr),
    .flag  (unexp_flag)
  );

  p_fallback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && dec_miss) |=> bus_valid && (bus_addr == FALLBACK_ADDR));

endmodule

// File: tb/test_port_window_xlate.sv
`timescale 1ns/1ps
module test_port_window_xlate;

  typedef struct packed {
    logic [15:0] port;
    logic        wr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [31:0] addr;
    logic [3:0]  be;
    logic        merge;
    logic        miss;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{16'h0300, 1'b0, 2'd0, 32'h0,        32'hA750_0000, 4'h1, 1'b0, 1'b0}, // R1 R9
    '{16'h030F, 1'b0, 2'd1, 32'h0,        32'hA750_000F, 4'h3, 1'b0, 1'b0}, // R1 R10
    '{16'h0290, 1'b1, 2'd2, 32'hDEADBEEF, 32'hA770_0000, 4'hF, 1'b0, 1'b0}, // R2 R10
    '{16'h0293, 1'b0, 2'd0, 32'h0,        32'hA770_0003, 4'h1, 1'b0, 1'b0}, // R2
    '{16'h03F0, 1'b0, 2'd0, 32'h0,        32'hA780_07E0, 4'h1, 1'b0, 1'b0}, // R3
    '{16'h03F1, 1'b1, 2'd0, 32'h0000005A, 32'hA780_07E2, 4'h1, 1'b0, 1'b0}, // R3 R10
    '{16'h01F7, 1'b0, 2'd1, 32'h0,        32'hA780_03EE, 4'h3, 1'b0, 1'b0}, // R3
    '{16'h03F6, 1'b1, 2'd1, 32'h0000C0DE, 32'hA780_07EC, 4'h3, 1'b0, 1'b0}, // R3
    '{16'h0170, 1'b0, 2'd0, 32'h0,        32'hA780_02E0, 4'h1, 1'b0, 1'b0}, // R3
    '{16'h0376, 1'b0, 2'd2, 32'h0,        32'hA780_06EC, 4'hF, 1'b0, 1'b0}, // R3
    '{16'h0407, 1'b0, 2'd0, 32'h0,        32'hA780_080E, 4'h1, 1'b0, 1'b0}, // R3
    '{16'h02F8, 1'b0, 2'd1, 32'h0,        32'hA780_05F0, 4'h3, 1'b0, 1'b0}, // R3
    '{16'h0302, 1'b0, 2'd0, 32'h0,        32'hA750_0002, 4'h1, 1'b0, 1'b0}, // R4
    '{16'h0307, 1'b1, 2'd1, 32'h00001357, 32'hA750_0007, 4'h3, 1'b0, 1'b0}, // R4
    '{16'h0310, 1'b0, 2'd0, 32'h0,        32'hFF00_0030, 4'h1, 1'b0, 1'b1}, // R5 R6
    '{16'h03F7, 1'b1, 2'd3, 32'h11223344, 32'hFF00_0030, 4'hF, 1'b0, 1'b1}, // R5 R10
    '{16'h0305, 1'b1, 2'd0, 32'h000000AB, 32'hA750_0004, 4'h3, 1'b1, 1'b0}, // R7 R8 odd
    '{16'h0306, 1'b1, 2'd0, 32'h000000CD, 32'hA750_0006, 4'h3, 1'b1, 1'b0}, // R7 R8 even
    '{16'h030F, 1'b1, 2'd0, 32'h000000EF, 32'hA750_000E, 4'h3, 1'b1, 1'b0}, // R7 R8 top
    '{16'h0300, 1'b1, 2'd0, 32'hFFFFFF12, 32'hA750_0000, 4'h3, 1'b1, 1'b0}, // R7 R8 base
    '{16'h0305, 1'b1, 2'd1, 32'h00004321, 32'hA750_0005, 4'h3, 1'b0, 1'b0}, // R10 word, no merge
    '{16'h0291, 1'b1, 2'd0, 32'h00000077, 32'hA770_0001, 4'h1, 1'b0, 1'b0}, // R10 byte elsewhere
    '{16'h0303, 1'b0, 2'd0, 32'h0,        32'hA750_0003, 4'h1, 1'b0, 1'b0}, // R9 odd read
    '{16'h0000, 1'b0, 2'd1, 32'h0,        32'hFF00_0030, 4'h3, 1'b0, 1'b1}  // R5 port zero
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_port = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic        bus_valid;
  logic        bus_ready = 1'b0;
  logic [31:0] bus_addr;
  logic        bus_write;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        unexp_clr = 1'b0;
  logic        unexp_flag;

  always #2 clk = ~clk;

  port_window_xlate i_port_window_xlate (.*);

  int checks = 0;
  int fails  = 0;

  logic [31:0] tx_addr [4];
  logic        tx_wr   [4];
  logic [3:0]  tx_be   [4];
  logic [31:0] tx_wd   [4];
  int          ntx;
  int          ntx_at_rsp;
  logic [31:0] got_rd;
  logic        rsp_unstable;
  logic        busy_ready;
  logic        timed_out;
  logic        exp_flag = 1'b0;

  function automatic logic [31:0] bus_model(input logic [31:0] a);
    return {16'h1234 ^ a[31:16], a[15:0] ^ 16'hA55A};
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // One full request: offer, serve the bus with one wait cycle, optionally stall the response.
  task automatic run_access(input vec_t v, input int hold, input logic clr_too);
    int   hold_cnt;
    logic waiting;
    logic fin;
    logic got;
    ntx = 0; ntx_at_rsp = -1; rsp_unstable = 0; busy_ready = 0; timed_out = 0;
    hold_cnt = 0; waiting = 0; fin = 0; got = 0; got_rd = '0;
    req_valid = 1'b1; req_port = v.port; req_write = v.wr;
    req_size = v.size; req_wdata = v.wdata; unexp_clr = clr_too;
    if (!req_ready) busy_ready = 1;
    @(negedge clk);
    req_valid = 1'b0; unexp_clr = 1'b0;
    for (int c = 0; c < 40; c++) begin
      bus_ready = 1'b0;
      rsp_ready = 1'b0;
      if (req_ready && !fin && c > 0 && !rsp_valid && !bus_valid) begin
        // idle again without a response would be a fault; handled by timeout
      end
      if (rsp_valid) begin
        if (req_ready) busy_ready = 1;
        if (!got) begin got_rd = rsp_rdata; got = 1; ntx_at_rsp = ntx; end
        else if (rsp_rdata != got_rd) rsp_unstable = 1;
        if (hold_cnt == hold) begin rsp_ready = 1'b1; fin = 1; end
        else hold_cnt++;
      end else if (bus_valid) begin
        if (req_ready) busy_ready = 1;
        if (!waiting) begin
          if (ntx < 4) begin
            tx_addr[ntx] = bus_addr; tx_wr[ntx] = bus_write;
            tx_be[ntx] = bus_be; tx_wd[ntx] = bus_wdata;
          end
          ntx++;
          waiting = 1;
        end else begin
          bus_ready = 1'b1;
          bus_rdata = bus_model(bus_addr);
          waiting = 0;
        end
      end
      @(negedge clk);
      if (fin) break;
    end
    bus_ready = 1'b0;
    rsp_ready = 1'b0;
    if (!fin) timed_out = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: state during and after reset
    check(req_ready == 1'b1 && bus_valid == 1'b0, "R12 idle in reset",
          {30'b0, req_ready, bus_valid}, 32'h2);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !bus_valid && !rsp_valid && !unexp_flag, "R12 after reset",
          {28'b0, req_ready, bus_valid, rsp_valid, unexp_flag}, 32'h8);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [31:0] rd;
      logic [15:0] mexp;
      v = VECS[i];
      run_access(v, (i % 3 == 1) ? 2 : 0, 1'b0);
      check(!timed_out, "R11 completion", {31'b0, timed_out}, 32'h0);
      check(!busy_ready, "R11 req_ready low while busy", {31'b0, busy_ready}, 32'h0);
      check(!rsp_unstable, "R11 rsp_rdata held", {31'b0, rsp_unstable}, 32'h0);
      check(ntx == (v.merge ? 2 : 1), v.merge ? "R7 transaction count" : "R10 transaction count",
            ntx, v.merge ? 2 : 1);
      check(ntx_at_rsp == ntx, "R11 response after last ack", ntx_at_rsp, ntx);
      check(tx_addr[0] == v.addr, v.miss ? "R5 address" : "R1/R2/R3/R4 address",
            tx_addr[0], v.addr);
      check(tx_be[0] == v.be, "R10 byte enables", {28'b0, tx_be[0]}, {28'b0, v.be});
      check(tx_wr[0] == (v.merge ? 1'b0 : v.wr), "R7 direction of first transaction",
            {31'b0, tx_wr[0]}, {31'b0, v.merge ? 1'b0 : v.wr});
      if (v.merge) begin
        rd   = bus_model(v.addr);
        mexp = v.port[0] ? {v.wdata[7:0], rd[7:0]} : {rd[15:8], v.wdata[7:0]};
        check(tx_addr[1] == v.addr && tx_wr[1] && tx_be[1] == 4'h3, "R7 merge write",
              tx_addr[1], v.addr);
        check(tx_wd[1] == {16'h0, mexp}, "R8 merged lanes", tx_wd[1], {16'h0, mexp});
      end else if (v.wr) begin
        check(tx_wd[0] == v.wdata, "R10 write data", tx_wd[0], v.wdata);
      end else begin
        check(got_rd == bus_model(v.addr), "R9 read data", got_rd, bus_model(v.addr));
      end
      exp_flag = exp_flag | v.miss;
      check(unexp_flag == exp_flag, "R6 sticky flag", {31'b0, unexp_flag}, {31'b0, exp_flag});
    end

    // R6: clear pulse with no request
    unexp_clr = 1'b1;
    @(negedge clk);
    unexp_clr = 1'b0;
    check(unexp_flag == 1'b0, "R6 clear", {31'b0, unexp_flag}, 32'h0);
    // R6: a hit request does not set the flag
    run_access(VECS[0], 0, 1'b0);
    check(unexp_flag == 1'b0, "R6 hit leaves flag clear", {31'b0, unexp_flag}, 32'h0);
    // R6: fallback accepted together with clear keeps the flag set
    run_access(VECS[14], 0, 1'b1);
    check(unexp_flag == 1'b1, "R6 set wins over clear", {31'b0, unexp_flag}, 32'h1);
    // R11: long response stall on a merged write
    run_access(VECS[16], 5, 1'b0);
    check(!timed_out && !rsp_unstable && ntx_at_rsp == 2, "R11 long stall on merge",
          ntx_at_rsp, 32'd2);
    // R12: reset mid-flight returns to idle
    req_valid = 1'b1; req_port = 16'h0305; req_write = 1'b1; req_size = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !bus_valid && !rsp_valid && !unexp_flag, "R12 reset mid-merge",
          {28'b0, req_ready, bus_valid, rsp_valid, unexp_flag}, 32'h8);

    finish_run();
  end

  int wd_cycles = 0;
  always @(posedge clk) begin
    wd_cycles++;
    if (wd_cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd_cycles);
      finish_run();
    end
  end

endmodule